// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block sits beside a processor core's execute stage and serves the instructions that move a word to or from a special-purpose register. The core presents a 16-bit base value and a 16-bit immediate; the block ORs them into a flat register address. The top five bits of that address are the group and the low eleven bits are the index within the group. Reads are combinational, so the core can take the result in the same cycle. Writes land on the rising clock edge while the write enable is high.

The block holds the supervision state: a version word, the exception vector base, the status word, the previous and exception program counters, the exception address and saved status, parameterised sets of 32 shadow general registers, a 64-bit multiply-accumulate register handled as two 32-bit halves, a power management word, and the interrupt mask and pending registers. It does not hold the program counter itself. The core supplies the current value and receives redirect requests. Writes with side effects raise single-cycle strobes toward the MMU (flush), toward fetch (redirect and delay-slot clear) and toward the clock controller (halt).

Top module: `spr_unit`

## Requirements
- R1: The access address is `base_i | imm_i`, with the group in bits [15:11] and the index in [10:0]. Group 0 serves version (0), unit-present (1), CPU config (2), data MMU config (3), instruction MMU config (4), vector base (11), next PC (16), status (17), previous PC (18), exception PC (32), exception address (48), exception status (64), core id (128) and core count (129). Group 5 serves the accumulator halves (1 and 2), group 8 serves power management (0), and group 9 serves the interrupt mask (0) and pending (2).
- R2: After reset, version reads the VERSION parameter and status reads STATUS_RST. Every other writable register reads zero. The config, core id and core count addresses read their parameters.
- R3: Writes to unit-present, the three config addresses, core id and core count change nothing.
- R4: Group 0 index 1024+32*s+r (s < SHADOW_SETS, r < 32) reads and writes shadow register r of set s.
- R5: A write to group 5 index 1 replaces only accumulator bits [31:0]. A write to index 2 replaces only bits [63:32]. Reads return the matching half.
- R6: A mask write ORs the data into the mask, so no mask bit is ever cleared.
- R7: A pending write clears each bit where the data is 1. `irq_set_i` sets pending bits on every edge, and a set wins over a clear in the same cycle.
- R8: A status write that changes bit 0 (supervisor), bit 5 (data MMU enable) or bit 6 (instruction MMU enable) pulses `tlb_flush_o` in the following cycle. Changes to other bits do not.
- R9: Next PC reads `cur_pc_i`. A write of a value other than `cur_pc_i` pulses `redirect_o` and `dslot_clr_o` in the following cycle, with `redirect_pc_o` equal to the data. A write equal to `cur_pc_i` raises nothing.
- R10: A power management write is stored. If bit 4 (doze) or bit 5 (sleep) of the data is set, `halt_o` and `redirect_o` pulse in the following cycle with `redirect_pc_o = cur_pc_i + 4`.
- R11: A read of any other address, including shadow indices past the last set, returns `rd_old_i`.
- R12: Strobes last exactly the cycle after the triggering write. With `wr_en_i` low, no register changes and no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| base_i | input | 16 | Base register value of the access |
| imm_i | input | 16 | Immediate offset of the access |
| wr_en_i | input | 1 | Write the addressed register at the next edge |
| wr_data_i | input | 32 | Write data |
| rd_old_i | input | 32 | Old destination value, returned for unserved reads |
| rd_data_o | output | 32 | Combinational read data |
| cur_pc_i | input | 32 | Current program counter of the core |
| irq_set_i | input | 32 | Interrupt lines that set pending bits |
| tlb_flush_o | output | 1 | TLB flush strobe |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Redirect target |
| dslot_clr_o | output | 1 | Delay-slot flag clear strobe |
| halt_o | output | 1 | Halt request strobe |

## Verification
A register that takes a wrong value stays wrong until the next write to it, so it shows up on `rd_data_o` at the first later read of that address, in the same cycle the address is presented. The bench therefore mixes random writes with reads of every address and checks all register values against a running model. A wrong stored status or a wrong PC comparison shows up one cycle after the write, as a missing or extra strobe. Because of this, every write is followed by a check of all four strobes and the redirect target. A decode fault that sends an address to the wrong place shows up either as a changed neighbour or as a pass-through of `rd_old_i` where a register was expected.

// File: rtl/spr_pkg.sv
// Shared definitions for the special-purpose register unit.
// Assumes a 16-bit flat address: group above bit 11, index below.
package spr_pkg;

    localparam int IDX_W       = 11;
    localparam int GRP_SYS     = 0;
    localparam int GRP_MAC     = 5;
    localparam int GRP_PWR     = 8;
    localparam int GRP_PIC     = 9;
    localparam int SHADOW_BASE = 1024;

    // Status bits whose change invalidates translations
    localparam int ST_SUPV     = 0;
    localparam int ST_DMMU     = 5;
    localparam int ST_IMMU     = 6;

    // Power management request bits
    localparam int PWR_DOZE    = 4;
    localparam int PWR_SLEEP   = 5;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_VER,
        SEL_UNITS,
        SEL_CPUCFG,
        SEL_DMMUCFG,
        SEL_IMMUCFG,
        SEL_VECBASE,
        SEL_NPC,
        SEL_STATUS,
        SEL_PPC,
        SEL_EPC,
        SEL_EEA,
        SEL_ESTAT,
        SEL_COREID,
        SEL_NCORES,
        SEL_SHADOW,
        SEL_ACCLO,
        SEL_ACCHI,
        SEL_PWR,
        SEL_IMASK,
        SEL_ISTAT
    } spr_sel_e;

endpackage

// File: rtl/spr_decode.sv
// Address decoder: maps a flat register address onto a register select
// and, for the shadow window, an entry index into the shadow bank.
// Assumes SHADOW_SETS*32 entries fit in the index space above 1024.
module spr_decode
    import spr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SHADOW_SETS = 2,
    localparam int SH_DEPTH   = SHADOW_SETS * 32,
    localparam int SH_IDX_W   = $clog2(SH_DEPTH),
    localparam int GRP_W      = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output spr_sel_e            sel_o,
    output logic [SH_IDX_W-1:0] sh_idx_o
);

    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] sh_off;

    // Split the address and pick the addressed register
    always_comb begin
        grp      = addr_i[ADDR_W-1:IDX_W];
        idx      = addr_i[IDX_W-1:0];
        sh_off   = idx - IDX_W'(SHADOW_BASE);
        sh_idx_o = sh_off[SH_IDX_W-1:0];
        sel_o    = SEL_NONE;
        if (grp == GRP_W'(GRP_SYS)) begin
            case (idx)
                11'd0:   sel_o = SEL_VER;
                11'd1:   sel_o = SEL_UNITS;
                11'd2:   sel_o = SEL_CPUCFG;
                11'd3:   sel_o = SEL_DMMUCFG;
                11'd4:   sel_o = SEL_IMMUCFG;
                11'd11:  sel_o = SEL_VECBASE;
                11'd16:  sel_o = SEL_NPC;
                11'd17:  sel_o = SEL_STATUS;
                11'd18:  sel_o = SEL_PPC;
                11'd32:  sel_o = SEL_EPC;
                11'd48:  sel_o = SEL_EEA;
                11'd64:  sel_o = SEL_ESTAT;
                11'd128: sel_o = SEL_COREID;
                11'd129: sel_o = SEL_NCORES;
                default: begin
                    if (idx >= IDX_W'(SHADOW_BASE) && 32'(sh_off) < SH_DEPTH)
                        sel_o = SEL_SHADOW;
                end
            endcase
        end else if (grp == GRP_W'(GRP_MAC)) begin
            if (idx == 11'd1)      sel_o = SEL_ACCLO;
            else if (idx == 11'd2) sel_o = SEL_ACCHI;
        end else if (grp == GRP_W'(GRP_PWR)) begin
            if (idx == 11'd0)      sel_o = SEL_PWR;
        end else if (grp == GRP_W'(GRP_PIC)) begin
            if (idx == 11'd0)      sel_o = SEL_IMASK;
            else if (idx == 11'd2) sel_o = SEL_ISTAT;
        end
    end

endmodule

// File: rtl/spr_shadow_bank.sv
// Shadow general register bank: one flop word per entry, a single index
// shared by the read and write paths. Reads are combinational.
module spr_shadow_bank #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 64,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Hold entry g, replace it when it is the write target
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                word_q[g] <= '0;
            else if (we_i && idx_i == IDX_W'(g))
                word_q[g] <= wdata_i;
        end
    end

    // Return the indexed entry
    always_comb rdata_o = word_q[idx_i];

endmodule

// File: rtl/spr_side_fx.sv
// Side-effect strobe generator: turns writes to status, next PC and power
// management into registered one-cycle strobes for the MMU, fetch and the
// clock controller. Assumes status_i is the value before the write.
module spr_side_fx
    import spr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  spr_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] cur_pc_i,
    output logic              tlb_flush_o,
    output logic              redirect_o,
    output logic [DATA_W-1:0] redirect_pc_o,
    output logic              dslot_clr_o,
    output logic              halt_o
);

    logic [DATA_W-1:0] track_mask;
    logic              flush_d;
    logic              npc_move_d;
    logic              halt_d;
    logic [DATA_W-1:0] target_d;

    // Work out which strobes this cycle's write raises
    always_comb begin
        track_mask           = '0;
        track_mask[ST_SUPV]  = 1'b1;
        track_mask[ST_DMMU]  = 1'b1;
        track_mask[ST_IMMU]  = 1'b1;
        flush_d    = wr_en_i && sel_i == SEL_STATUS
                     && ((status_i ^ wdata_i) & track_mask) != '0;
        npc_move_d = wr_en_i && sel_i == SEL_NPC && wdata_i != cur_pc_i;
        halt_d     = wr_en_i && sel_i == SEL_PWR
                     && (wdata_i[PWR_DOZE] || wdata_i[PWR_SLEEP]);
        target_d   = halt_d ? cur_pc_i + DATA_W'(4) : wdata_i;
    end

    // Register the strobes so each lasts one cycle
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tlb_flush_o   <= 1'b0;
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
            dslot_clr_o   <= 1'b0;
            halt_o        <= 1'b0;
        end else begin
            tlb_flush_o   <= flush_d;
            redirect_o    <= npc_move_d || halt_d;
            dslot_clr_o   <= npc_move_d;
            halt_o        <= halt_d;
            if (npc_move_d || halt_d)
                redirect_pc_o <= target_d;
        end
    end

endmodule

// File: rtl/spr_unit.sv
// Special-purpose register unit top. Decodes base|imm, serves combinational
// reads and edge-triggered writes with per-register write rules, and raises
// side-effect strobes. Assumes the core owns the PC and supplies it.
module spr_unit
    import spr_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 32,
    parameter int          SHADOW_SETS = 2,
    parameter logic [31:0] VERSION     = 32'h1200_0001,
    parameter logic [31:0] UNITS_CFG   = 32'h0000_0619,
    parameter logic [31:0] CPU_CFG     = 32'h0000_0020,
    parameter logic [31:0] DMMU_CFG    = 32'h0000_0018,
    parameter logic [31:0] IMMU_CFG    = 32'h0000_0019,
    parameter logic [31:0] STATUS_RST  = 32'h0000_8001,
    parameter int          CORE_ID     = 0,
    parameter int          CORE_COUNT  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] imm_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] rd_old_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [DATA_W-1:0] cur_pc_i,
    input  logic [DATA_W-1:0] irq_set_i,
    output logic              tlb_flush_o,
    output logic              redirect_o,
    output logic [DATA_W-1:0] redirect_pc_o,
    output logic              dslot_clr_o,
    output logic              halt_o
);

    localparam int SH_DEPTH = SHADOW_SETS * 32;
    localparam int SH_IDX_W = $clog2(SH_DEPTH);
    localparam int ACC_W    = 2 * DATA_W;

    logic [ADDR_W-1:0]   addr;
    spr_sel_e            sel;
    logic [SH_IDX_W-1:0] sh_idx;
    logic [DATA_W-1:0]   sh_rdata;
    logic                sh_we;

    logic [DATA_W-1:0] ver_q, vbase_q, status_q, ppc_q, epc_q, eea_q, estat_q;
    logic [DATA_W-1:0] pwr_q, imask_q, istat_q;
    logic [ACC_W-1:0]  acc_q;
    logic [DATA_W-1:0] istat_clr;

    // Form the flat access address
    always_comb addr = base_i | imm_i;

    spr_decode #(
        .ADDR_W      (ADDR_W),
        .SHADOW_SETS (SHADOW_SETS)
    ) u_decode (
        .addr_i   (addr),
        .sel_o    (sel),
        .sh_idx_o (sh_idx)
    );

    // Shadow bank write enable
    always_comb sh_we = wr_en_i && sel == SEL_SHADOW;

    spr_shadow_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (SH_DEPTH)
    ) u_shadow (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (sh_we),
        .idx_i   (sh_idx),
        .wdata_i (wr_data_i),
        .rdata_o (sh_rdata)
    );

    spr_side_fx #(
        .DATA_W (DATA_W)
    ) u_fx (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .sel_i         (sel),
        .wdata_i       (wr_data_i),
        .status_i      (status_q),
        .cur_pc_i      (cur_pc_i),
        .tlb_flush_o   (tlb_flush_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .dslot_clr_o   (dslot_clr_o),
        .halt_o        (halt_o)
    );

    // Plain and OR-only registers; read-only selects fall through
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ver_q    <= DATA_W'(VERSION);
            vbase_q  <= '0;
            status_q <= DATA_W'(STATUS_RST);
            ppc_q    <= '0;
            epc_q    <= '0;
            eea_q    <= '0;
            estat_q  <= '0;
            pwr_q    <= '0;
            imask_q  <= '0;
        end else if (wr_en_i) begin
            case (sel)
                SEL_VER:     ver_q    <= wr_data_i;
                SEL_VECBASE: vbase_q  <= wr_data_i;
                SEL_STATUS:  status_q <= wr_data_i;
                SEL_PPC:     ppc_q    <= wr_data_i;
                SEL_EPC:     epc_q    <= wr_data_i;
                SEL_EEA:     eea_q    <= wr_data_i;
                SEL_ESTAT:   estat_q  <= wr_data_i;
                SEL_PWR:     pwr_q    <= wr_data_i;
                SEL_IMASK:   imask_q  <= imask_q | wr_data_i;
                default:     ;
            endcase
        end
    end

    // Accumulator: each write replaces only the addressed half
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            acc_q <= '0;
        else if (wr_en_i && sel == SEL_ACCLO)
            acc_q[DATA_W-1:0] <= wr_data_i;
        else if (wr_en_i && sel == SEL_ACCHI)
            acc_q[ACC_W-1:DATA_W] <= wr_data_i;
    end

    // Pending clear mask from a write-one-to-clear access
    always_comb istat_clr = (wr_en_i && sel == SEL_ISTAT) ? wr_data_i : '0;

    // Pending register: lines set, write clears, set wins
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            istat_q <= '0;
        else
            istat_q <= (istat_q & ~istat_clr) | irq_set_i;
    end

    // Read multiplexer, unserved addresses return the old value
    always_comb begin
        case (sel)
            SEL_VER:     rd_data_o = ver_q;
            SEL_UNITS:   rd_data_o = DATA_W'(UNITS_CFG);
            SEL_CPUCFG:  rd_data_o = DATA_W'(CPU_CFG);
            SEL_DMMUCFG: rd_data_o = DATA_W'(DMMU_CFG);
            SEL_IMMUCFG: rd_data_o = DATA_W'(IMMU_CFG);
            SEL_VECBASE: rd_data_o = vbase_q;
            SEL_NPC:     rd_data_o = cur_pc_i;
            SEL_STATUS:  rd_data_o = status_q;
            SEL_PPC:     rd_data_o = ppc_q;
            SEL_EPC:     rd_data_o = epc_q;
            SEL_EEA:     rd_data_o = eea_q;
            SEL_ESTAT:   rd_data_o = estat_q;
            SEL_COREID:  rd_data_o = DATA_W'(CORE_ID);
            SEL_NCORES:  rd_data_o = DATA_W'(CORE_COUNT);
            SEL_SHADOW:  rd_data_o = sh_rdata;
            SEL_ACCLO:   rd_data_o = acc_q[DATA_W-1:0];
            SEL_ACCHI:   rd_data_o = acc_q[ACC_W-1:DATA_W];
            SEL_PWR:     rd_data_o = pwr_q;
            SEL_IMASK:   rd_data_o = imask_q;
            SEL_ISTAT:   rd_data_o = istat_q;
            default:     rd_data_o = rd_old_i;
        endcase
    end

    // R6: the mask keeps every bit it held
    assert_mask_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imask_q & $past(imask_q)) == $past(imask_q));

    // R5: a low-half write leaves the high half alone
    assert_acc_hi_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && sel == SEL_ACCLO) |=> $stable(acc_q[ACC_W-1:DATA_W]));

    // R7: written ones are gone next cycle unless a line set them
    assert_pending_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && sel == SEL_ISTAT) |=>
        ((istat_q & $past(wr_data_i) & ~$past(irq_set_i)) == '0));

    // R8: a flush only follows a status write
    assert_flush_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlb_flush_o |-> $past(wr_en_i && sel == SEL_STATUS));

    // R10: a halt only follows a power write with doze or sleep
    assert_halt_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |-> $past(wr_en_i && sel == SEL_PWR
                         && (wr_data_i[PWR_DOZE] || wr_data_i[PWR_SLEEP])));

    // R12: status holds while no write is presented
    assert_status_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(status_q));

    // R11: unserved addresses pass the old value through
    always_comb begin
        if (rst_ni && sel == SEL_NONE)
            assert_old_passthru_R11: assert (rd_data_o == rd_old_i);
    end

endmodule

// File: tb/sim_spr_unit.sv
`timescale 1ns/1ps
module sim_spr_unit;

    localparam logic [31:0] P_VER   = 32'h1200_0001;
    localparam logic [31:0] P_UNITS = 32'h0000_0619;
    localparam logic [31:0] P_CPU   = 32'h0000_0020;
    localparam logic [31:0] P_DMMU  = 32'h0000_0018;
    localparam logic [31:0] P_IMMU  = 32'h0000_0019;
    localparam logic [31:0] P_STRST = 32'h0000_8001;
    localparam int          P_CID   = 3;
    localparam int          P_NCORE = 4;
    localparam int          SETS    = 2;
    localparam int          SH_N    = SETS * 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base, imm;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0, rd_old = '0, rd_data;
    logic [31:0] cur_pc = '0, irq_set = '0;
    logic        tlb_flush, redirect, dslot_clr, halt;
    logic [31:0] redirect_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of architectural state
    logic [31:0] m_ver, m_vb, m_st, m_ppc, m_epc, m_eea, m_est, m_pwr, m_imask, m_istat;
    logic [63:0] m_acc;
    logic [31:0] m_sh [SH_N];

    always #5 clk = ~clk;

    spr_unit #(
        .ADDR_W (16), .DATA_W (32), .SHADOW_SETS (SETS),
        .VERSION (P_VER), .UNITS_CFG (P_UNITS), .CPU_CFG (P_CPU),
        .DMMU_CFG (P_DMMU), .IMMU_CFG (P_IMMU), .STATUS_RST (P_STRST),
        .CORE_ID (P_CID), .CORE_COUNT (P_NCORE)
    ) u0 (
        .clk_i (clk), .rst_ni (rst_n), .base_i (base), .imm_i (imm),
        .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_old_i (rd_old),
        .rd_data_o (rd_data), .cur_pc_i (cur_pc), .irq_set_i (irq_set),
        .tlb_flush_o (tlb_flush), .redirect_o (redirect),
        .redirect_pc_o (redirect_pc), .dslot_clr_o (dslot_clr), .halt_o (halt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] exp_read(input logic [15:0] a, input logic [31:0] old,
                                             input logic [31:0] pc);
        if (a >= 16'h0400 && a < 16'h0400 + 16'(SH_N)) return m_sh[a - 16'h0400];
        case (a)
            16'h0000: return m_ver;
            16'h0001: return P_UNITS;
            16'h0002: return P_CPU;
            16'h0003: return P_DMMU;
            16'h0004: return P_IMMU;
            16'h000B: return m_vb;
            16'h0010: return pc;
            16'h0011: return m_st;
            16'h0012: return m_ppc;
            16'h0020: return m_epc;
            16'h0030: return m_eea;
            16'h0040: return m_est;
            16'h0080: return 32'(P_CID);
            16'h0081: return 32'(P_NCORE);
            16'h2801: return m_acc[31:0];
            16'h2802: return m_acc[63:32];
            16'h4000: return m_pwr;
            16'h4800: return m_imask;
            16'h4802: return m_istat;
            default:  return old;
        endcase
    endfunction

    task automatic model_reset();
        m_ver = P_VER; m_vb = '0; m_st = P_STRST; m_ppc = '0; m_epc = '0;
        m_eea = '0; m_est = '0; m_pwr = '0; m_imask = '0; m_istat = '0; m_acc = '0;
        for (int i = 0; i < SH_N; i++) m_sh[i] = '0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [31:0] d, input logic [31:0] irq);
        logic [31:0] clr;
        clr = (a == 16'h4802) ? d : '0;
        if (a >= 16'h0400 && a < 16'h0400 + 16'(SH_N)) m_sh[a - 16'h0400] = d;
        case (a)
            16'h0000: m_ver = d;
            16'h000B: m_vb = d;
            16'h0011: m_st = d;
            16'h0012: m_ppc = d;
            16'h0020: m_epc = d;
            16'h0030: m_eea = d;
            16'h0040: m_est = d;
            16'h2801: m_acc[31:0] = d;
            16'h2802: m_acc[63:32] = d;
            16'h4000: m_pwr = d;
            16'h4800: m_imask = m_imask | d;
            default: ;
        endcase
        m_istat = (m_istat & ~clr) | irq;
    endtask

    // R1: present an address as two overlapping OR operands
    task automatic drive_addr(input logic [15:0] a);
        logic [15:0] r1, r2;
        r1 = 16'($urandom); r2 = 16'($urandom);
        base = a & r1;
        imm  = (a & ~r1) | (a & r2);
    endtask

    task automatic do_read(input logic [15:0] a, input string req);
        logic [31:0] old;
        old = $urandom;
        drive_addr(a);
        rd_old  = old;
        cur_pc  = $urandom;
        wr_data = $urandom;       // R12: data present with enable low
        wr_en   = 1'b0;
        #1;
        check(req, rd_data, exp_read(a, old, cur_pc));
        @(negedge clk);
        check("R12 no strobe without write", {28'd0, tlb_flush, redirect, dslot_clr, halt}, 32'd0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [31:0] irq,
                            input logic [31:0] pc, input string req);
        logic e_fl, e_ds, e_ht, e_rd;
        logic [31:0] e_pc;
        e_fl = (a == 16'h0011) && (((m_st ^ d) & 32'h0000_0061) != 0);
        e_ds = (a == 16'h0010) && (d != pc);
        e_ht = (a == 16'h4000) && (d[5:4] != 2'b00);
        e_rd = e_ds || e_ht;
        e_pc = e_ht ? pc + 32'd4 : d;
        drive_addr(a);
        cur_pc = pc; wr_data = d; irq_set = irq; wr_en = 1'b1;
        @(posedge clk);
        model_write(a, d, irq);
        @(negedge clk);
        wr_en = 1'b0; irq_set = '0;
        check(req, {28'd0, tlb_flush, redirect, dslot_clr, halt}, {28'd0, e_fl, e_rd, e_ds, e_ht});
        if (e_rd) check({req, " target"}, redirect_pc, e_pc);
    endtask

    function automatic logic [15:0] pick_addr(input int k);
        case (k)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
            3: return 16'h0003;  4: return 16'h0004;  5: return 16'h000B;
            6: return 16'h0010;  7: return 16'h0011;  8: return 16'h0012;
            9: return 16'h0020; 10: return 16'h0030; 11: return 16'h0040;
           12: return 16'h0080; 13: return 16'h0081; 14: return 16'h2801;
           15: return 16'h2802; 16: return 16'h4000; 17: return 16'h4800;
           18: return 16'h4802; 19: return 16'h0005; 20: return 16'h0800;
           21: return 16'h5000; 22: return 16'h0400 + 16'(SH_N);
           default: return 16'h0400 + 16'($urandom % SH_N);
        endcase
    endfunction

    // watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [31:0] pc;
        void'($urandom(32'd20240611));
        base = '0; imm = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state of every served address
        for (int k = 0; k < 22; k++) do_read(pick_addr(k), "R2 reset value");
        do_read(16'h0400, "R2 shadow reset");

        // R3: read-only addresses ignore writes
        do_write(16'h0001, 32'hFFFF_FFFF, '0, 32'h100, "R3 strobes");
        do_write(16'h0080, 32'h0000_0077, '0, 32'h100, "R3 strobes");
        do_write(16'h0081, 32'h0000_0055, '0, 32'h100, "R3 strobes");
        do_write(16'h0003, 32'h1234_5678, '0, 32'h100, "R3 strobes");
        do_read(16'h0001, "R3 unit-present"); do_read(16'h0080, "R3 core id");
        do_read(16'h0081, "R3 core count"); do_read(16'h0003, "R3 dmmu cfg");

        // R6: mask is OR-only
        do_write(16'h4800, 32'h0000_000F, '0, 32'h0, "R6 strobes");
        do_write(16'h4800, 32'h0000_00F0, '0, 32'h0, "R6 strobes");
        do_write(16'h4800, 32'h0000_0000, '0, 32'h0, "R6 strobes");
        do_read(16'h4800, "R6 mask OR");

        // R7: write-one-to-clear, set wins
        do_write(16'h0012, 32'h1, 32'h0000_00A5, 32'h0, "R7 strobes");
        do_write(16'h4802, 32'h0000_0005, 32'h0000_0001, 32'h0, "R7 strobes");
        do_read(16'h4802, "R7 pending clear/set");

        // R5: accumulator halves
        do_write(16'h2801, 32'hDEAD_BEEF, '0, 32'h0, "R5 strobes");
        do_write(16'h2802, 32'hCAFE_F00D, '0, 32'h0, "R5 strobes");
        do_write(16'h2801, 32'h0101_0101, '0, 32'h0, "R5 strobes");
        do_read(16'h2801, "R5 acc low"); do_read(16'h2802, "R5 acc high");

        // R8: only tracked status bits flush
        do_write(16'h0011, m_st ^ 32'h0000_0002, '0, 32'h0, "R8 untracked change");
        do_write(16'h0011, m_st ^ 32'h0000_0040, '0, 32'h0, "R8 immu change");
        do_write(16'h0011, m_st ^ 32'h0000_0001, '0, 32'h0, "R8 supervisor change");
        do_write(16'h0011, m_st, '0, 32'h0, "R8 no change");

        // R9: next PC writes
        do_write(16'h0010, 32'h0000_2000, '0, 32'h0000_2000, "R9 equal pc");
        do_write(16'h0010, 32'h0000_3000, '0, 32'h0000_2000, "R9 redirect");
        do_read(16'h0010, "R9 npc read");

        // R10: power management
        do_write(16'h4000, 32'h0000_0010, '0, 32'h0000_4000, "R10 doze");
        do_write(16'h4000, 32'h0000_0020, '0, 32'hFFFF_FFFC, "R10 sleep wrap");
        do_write(16'h4000, 32'h0000_0008, '0, 32'h0000_4000, "R10 no halt");
        do_read(16'h4000, "R10 stored");

        // R4 / R11: shadow window edges
        do_write(16'h0400, 32'h1111_1111, '0, 32'h0, "R4 strobes");
        do_write(16'h0400 + 16'(SH_N - 1), 32'h2222_2222, '0, 32'h0, "R4 strobes");
        do_write(16'h0400 + 16'(SH_N), 32'h3333_3333, '0, 32'h0, "R11 strobes");
        do_read(16'h0400, "R4 first entry");
        do_read(16'h0400 + 16'(SH_N - 1), "R4 last entry");
        do_read(16'h0400 + 16'(SH_N), "R11 past shadow");
        do_read(16'h0800, "R11 group 1"); do_read(16'h5000, "R11 group 10");
        do_read(16'h0005, "R11 group 0 hole");

        // random mix
        for (int i = 0; i < 900; i++) begin
            logic [15:0] a;
            logic [31:0] d, irq;
            a   = pick_addr($urandom % 26);
            pc  = $urandom & 32'hFFFF_FFFC;
            d   = $urandom;
            irq = (($urandom % 4) == 0) ? (32'($urandom) & 32'h0000_0F0F) : 32'd0;
            if (a == 16'h0010 && $urandom % 2 == 0) d = pc;
            if (a == 16'h4000 && $urandom % 2 == 0) d = d & ~32'h30;
            if ($urandom % 2 == 0) do_write(a, d, irq, pc, "R1 random write strobes");
            else                  do_read(a, "R1 random read");
        end

        done = 1'b1;
        summary();
    end

endmodule